// File: doc/BRIEF.md
# Generated Clock Source Selector and Divider

This block derives one peripheral's generated clock from a small set of candidate source clocks. All sources and the result are carried as single-cycle tick strobes inside one system clock domain, so the whole block is ordinary synchronous logic. A select field picks which source ticks are considered. An integer divider then lets one out of every N of those ticks through, and a gate bit switches the result on or off.

Configuration arrives as a select value, a divider field and a gate bit, qualified by a load strobe. Source and divider may only be changed while the output is gated off. A load that arrives while the output runs may only switch it off; any other such load is dropped and raises a sticky error flag. After reset the block takes its initial select, divider and gate from a set of boot configuration inputs instead of fixed constants. A block built for a peripheral slot number below a threshold (2 by default) runs in pass-through mode: it forwards the selected source unchanged, ignores the divider and the gate, and reports itself as always enabled.

Top module: `gclk_gen`

## Requirements
- R1: With select value s in 0 to 5, the output ticks only in cycles where `src_tick[s]` ticks; no other source affects the output.
- R2: Select values 6 and 7 pick no source, and the output never ticks while either is active.
- R3: The divider field d (8 bits) gives a ratio of d+1, from 1 to 256: while enabled, the output ticks on every (d+1)-th tick of the selected source.
- R4: With d = 0 every selected source tick appears on the output in the same cycle.
- R5: While the gate bit is 0 the output does not tick, and `gclk_enabled` is 0; while it is 1, `gclk_enabled` is 1.
- R6: The divide count restarts from zero whenever the output is enabled, so the first output tick falls on exactly the (d+1)-th selected tick after the enabling load.
- R7: A load while the output is gated off takes select, divider and gate from the cfg inputs at that clock edge; the new setting governs the output from the next cycle.
- R8: A load with `cfg_en` = 1 while the output is enabled is ignored and sets `cfg_err`, which stays set until reset.
- R9: A load with `cfg_en` = 0 while the output is enabled gates the output off, keeps select and divider, and does not set `cfg_err`.
- R10: During reset the output is silent, `gclk_enabled` and `cfg_err` are 0. The first clock edge after reset release loads select, divider and gate from `boot_sel`, `boot_div` and `boot_en`; a load in that cycle is ignored.
- R11: When `SLOT_ID` is below `BYPASS_BELOW`, the output equals the selected source tick in every cycle regardless of gate and divider, `gclk_enabled` is always 1, `cfg_err` stays 0, and every load after the boot cycle changes the select at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One tick strobe per candidate source |
| boot_sel | input | 3 | Select value taken after reset |
| boot_div | input | 8 | Divider field taken after reset |
| boot_en | input | 1 | Gate bit taken after reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_sel | input | 3 | Requested source select |
| cfg_div | input | 8 | Requested divider field (ratio minus one) |
| cfg_en | input | 1 | Requested gate bit |
| gclk_tick | output | 1 | Generated clock tick strobe |
| gclk_enabled | output | 1 | Output is currently enabled |
| cfg_err | output | 1 | Sticky flag: a load was refused while enabled |

## Verification
The assertions assume source ticks are already synchronous strobes of the system clock and that the boot configuration inputs are steady across the first edge after reset; they make no claim about the pattern or density of source ticks. The stimulus drives every input half a cycle away from the active edge, holds the boot inputs constant for the whole run, and only issues loads after the boot cycle. Source ticks are drawn from dense, sparse and all-active patterns so that the divide count wraps, restarts and sees back-to-back ticks.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  localparam int GCLK_SEL_W = 3;
  localparam int GCLK_DIV_W = 8;

  typedef struct packed {
    logic                  en;
    logic [GCLK_SEL_W-1:0] sel;
    logic [GCLK_DIV_W-1:0] div;
  } gclk_cfg_t;
endpackage

// File: rtl/gclk_src_sel.sv
module gclk_src_sel
  import gclk_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0]    src_tick,
  input  logic [GCLK_SEL_W-1:0] sel,
  output logic                  sel_tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign hit[g] = src_tick[g] && (sel == GCLK_SEL_W'(g));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/gclk_cfg.sv
module gclk_cfg
  import gclk_pkg::*;
#(
  parameter bit BYPASS = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gclk_cfg_t boot_cfg,
  input  logic      load,
  input  gclk_cfg_t req_cfg,
  output gclk_cfg_t cur_cfg,
  output logic      take,
  output logic      err
);
  gclk_cfg_t cfg_q, cfg_d;
  logic      booted_q, booted_d;
  logic      err_q, err_d;
  logic      take_d;

  always_comb begin
    cfg_d    = cfg_q;
    err_d    = err_q;
    booted_d = booted_q;
    take_d   = 1'b0;
    if (!booted_q) begin
      cfg_d    = boot_cfg;
      booted_d = 1'b1;
      take_d   = 1'b1;
    end else if (load) begin
      if (BYPASS) begin
        cfg_d.sel = req_cfg.sel;
        take_d    = 1'b1;
      end else if (!cfg_q.en) begin
        cfg_d  = req_cfg;
        take_d = 1'b1;
      end else if (!req_cfg.en) begin
        cfg_d.en = 1'b0;
        take_d   = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      booted_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      booted_q <= booted_d;
      err_q    <= err_d;
    end
  end

  assign cur_cfg = cfg_q;
  assign take    = take_d;
  assign err     = err_q;

  // R8: a refused load leaves the active setting untouched and flags it
  assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!BYPASS && booted_q && load && cfg_q.en && req_cfg.en)
      |=> ($stable(cfg_q) && err_q));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: switching off while running keeps select and divider
  assert_off_keeps_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!BYPASS && booted_q && load && cfg_q.en && !req_cfg.en)
      |=> (!cfg_q.en && $stable(cfg_q.sel) && $stable(cfg_q.div) && $stable(err_q)));
endmodule

// File: rtl/gclk_div.sv
module gclk_div
  import gclk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  clr,
  input  logic                  tick,
  input  logic [GCLK_DIV_W-1:0] div_val,
  output logic                  out_tick
);
  logic [GCLK_DIV_W-1:0] cnt_q, cnt_d;
  logic                  at_end;

  assign at_end = (cnt_q == div_val);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign out_tick = en && tick && at_end;

  // R6: counting always starts from zero when the output comes on
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (cnt_q == '0));

  // R3: the count never runs past the programmed terminal value
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= div_val));
endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int NUM_SRC      = 6,
  parameter int SLOT_ID      = 5,
  parameter int BYPASS_BELOW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_tick,
  input  logic [GCLK_SEL_W-1:0] boot_sel,
  input  logic [GCLK_DIV_W-1:0] boot_div,
  input  logic                  boot_en,
  input  logic                  cfg_load,
  input  logic [GCLK_SEL_W-1:0] cfg_sel,
  input  logic [GCLK_DIV_W-1:0] cfg_div,
  input  logic                  cfg_en,
  output logic                  gclk_tick,
  output logic                  gclk_enabled,
  output logic                  cfg_err
);
  localparam bit BYPASS = (SLOT_ID < BYPASS_BELOW);
  localparam logic [GCLK_SEL_W-1:0] SEL_LAST = GCLK_SEL_W'(NUM_SRC - 1);

  gclk_cfg_t boot_cfg, req_cfg, cur_cfg;
  logic      take;
  logic      sel_tick;

  assign boot_cfg = '{en: boot_en, sel: boot_sel, div: boot_div};
  assign req_cfg  = '{en: cfg_en,  sel: cfg_sel,  div: cfg_div};

  gclk_cfg #(.BYPASS(BYPASS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_cfg (boot_cfg),
    .load     (cfg_load),
    .req_cfg  (req_cfg),
    .cur_cfg  (cur_cfg),
    .take     (take),
    .err      (cfg_err)
  );

  gclk_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_tick (src_tick),
    .sel      (cur_cfg.sel),
    .sel_tick (sel_tick)
  );

  if (BYPASS) begin : g_pass
    assign gclk_tick    = sel_tick;
    assign gclk_enabled = 1'b1;

    // R11: pass-through mode never raises the error flag
    assert_pass_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err);
  end else begin : g_divided
    gclk_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cur_cfg.en),
      .clr      (take),
      .tick     (sel_tick),
      .div_val  (cur_cfg.div),
      .out_tick (gclk_tick)
    );
    assign gclk_enabled = cur_cfg.en;

    // R5: a gated output is silent
    assert_gated_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gclk_enabled |-> !gclk_tick);

    // R4: ratio one forwards every selected tick at once
    assert_ratio_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gclk_enabled && cur_cfg.div == '0 && sel_tick) |-> gclk_tick);
  end

  // R1: an output tick always coincides with a tick of the chosen source
  assert_tick_from_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gclk_tick |-> ((cur_cfg.sel <= SEL_LAST) && src_tick[cur_cfg.sel]));

  // R2: out-of-range select values produce nothing
  assert_no_tick_bad_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cfg.sel > SEL_LAST) |-> !gclk_tick);
endmodule

// File: tb/gclk_gen_tb.sv
module gclk_gen_tb;
  logic       clk;
  logic       rst_n;
  logic [5:0] src;
  logic [2:0] boot_sel;
  logic [7:0] boot_div;
  logic       boot_en;
  logic       cfg_load;
  logic [2:0] cfg_sel;
  logic [7:0] cfg_div;
  logic       cfg_en;
  logic       m_tick, m_enabled, m_err;
  logic       b_tick, b_enabled, b_err;

  int checks = 0;
  int errors = 0;
  string req = "R10";

  // reference model state
  int m_sel, m_div, m_cnt;
  bit m_en, m_errf, m_booted;
  int b_sel;
  bit b_booted;

  gclk_gen #(.NUM_SRC(6), .SLOT_ID(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src),
    .boot_sel(boot_sel), .boot_div(boot_div), .boot_en(boot_en),
    .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_div(cfg_div), .cfg_en(cfg_en),
    .gclk_tick(m_tick), .gclk_enabled(m_enabled), .cfg_err(m_err)
  );

  gclk_gen #(.NUM_SRC(6), .SLOT_ID(1)) u_byp (
    .clk(clk), .rst_n(rst_n), .src_tick(src),
    .boot_sel(boot_sel), .boot_div(boot_div), .boot_en(boot_en),
    .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_div(cfg_div), .cfg_en(cfg_en),
    .gclk_tick(b_tick), .gclk_enabled(b_enabled), .cfg_err(b_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit hit(int s);
    return (s < 6) && src[s];
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sel = 0; m_div = 0; m_cnt = 0; m_en = 0; m_errf = 0; m_booted = 0;
    b_sel = 0; b_booted = 0;
  endtask

  task automatic model_edge();
    bit tk;
    if (!rst_n) begin
      model_reset();
      return;
    end
    tk = hit(m_sel);
    if (!m_booted) begin
      m_sel = boot_sel; m_div = boot_div; m_en = boot_en; m_cnt = 0; m_booted = 1;
    end else if (cfg_load && !m_en) begin
      m_sel = cfg_sel; m_div = cfg_div; m_en = cfg_en; m_cnt = 0;
    end else if (cfg_load && !cfg_en) begin
      m_en = 0; m_cnt = 0;
    end else begin
      if (cfg_load) m_errf = 1;
      if (m_en && tk) m_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
    end
    if (!b_booted) begin
      b_sel = boot_sel; b_booted = 1;
    end else if (cfg_load) begin
      b_sel = cfg_sel;
    end
  endtask

  // inputs are set just after a falling edge; compare, then step the model
  task automatic cyc();
    #5;
    chk(req, "tick", m_tick, m_booted && m_en && hit(m_sel) && (m_cnt == m_div));
    chk(req, "enabled", m_enabled, m_en);
    chk(req, "err", m_err, m_errf);
    chk("R11", "pass tick", b_tick, hit(b_sel));
    chk("R11", "pass enabled", b_enabled, 1'b1);
    chk("R11", "pass err", b_err, 1'b0);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run(int n, int density);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 6; k++) src[k] = ($urandom_range(99) < density);
      cyc();
    end
    src = '0;
  endtask

  task automatic load(bit en, int sel, int dv);
    cfg_load = 1'b1; cfg_en = en; cfg_sel = 3'(sel); cfg_div = 8'(dv);
    cyc();
    cfg_load = 1'b0;
  endtask

  initial begin
    model_reset();
    rst_n = 1'b0; src = '0; cfg_load = 1'b0; cfg_sel = '0; cfg_div = '0; cfg_en = 1'b0;
    boot_sel = 3'd2; boot_div = 8'd3; boot_en = 1'b1;
    @(negedge clk);
    req = "R10";
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1'b1;
    // boot cycle: a load here must be ignored
    cfg_load = 1'b1; cfg_en = 1'b1; cfg_sel = 3'd5; cfg_div = 8'd0;
    cyc();
    cfg_load = 1'b0;
    run(40, 60);
    req = "R8";
    load(1, 0, 0);
    run(10, 60);
    load(1, 4, 9);
    run(5, 60);
    req = "R9";
    load(0, 5, 7);
    req = "R5";
    run(20, 100);
    req = "R4";
    load(1, 1, 0);
    run(30, 50);
    req = "R1";
    for (int s = 0; s < 6; s++) begin
      load(0, 0, 0);
      load(1, s, 1);
      run(25, 55);
    end
    req = "R2";
    load(0, 0, 0);
    load(1, 6, 0);
    run(15, 100);
    load(0, 0, 0);
    load(1, 7, 0);
    run(15, 100);
    req = "R3";
    load(0, 0, 0);
    load(1, 0, 255);
    for (int i = 0; i < 600; i++) begin src = 6'b000001; cyc(); end
    src = '0;
    load(0, 0, 0);
    load(1, 2, 2);
    run(60, 40);
    req = "R6";
    load(0, 0, 0);
    load(1, 3, 4);
    for (int i = 0; i < 3; i++) begin src = 6'b001000; cyc(); end
    load(0, 3, 4);
    src = 6'b001000;
    load(1, 3, 4);
    for (int i = 0; i < 12; i++) begin src = 6'b001000; cyc(); end
    src = '0;
    req = "R7";
    load(0, 0, 0);
    load(1, 5, 0);
    run(20, 70);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule